// File: doc/BRIEF.md
# Light-Tracking Sample-and-Step Controller

This controller keeps a light collector pointed at its brightest spot. It wakes up at a fixed long interval and runs one conversion on an external 8-bit successive-approximation converter through a strict pin handshake. It reads the light code and weighs it against the code kept from the previous wake-up. When the change is large enough, it asks a stepper sequencer to take one move forward or backward.

The converter side has these plain control pins: an address latch strobe, a start strobe, an end-of-conversion input and an output enable. The controller drives the output enable only for the one cycle in which it captures the data bus. The move interface works like a valid/ready pair. The request is the valid and the done input is the ready. Once raised, the request and the direction are held steady for as long as the sequencer withholds done, so the sequencer can apply back-pressure for any length of time. The transfer completes at the clock edge where both are high. No new conversion is started while a move is outstanding.

A minimum-difference input sets how far the light code must change before a move is asked for. A watchdog on the end-of-conversion wait raises an error flag if the converter never answers.

Top module: `light_track_ctrl`

## Requirements
- R1: While reset is low, all outputs are 0. After reset is released, the controller waits IDLE_CYCLES cycles, and the first start strobe appears in the cycle after that wait.
- R2: A conversion begins with one cycle in which adc_ale and adc_start are both 1. In the following cycle both are 0.
- R3: After the start cycle the controller waits for adc_eoc=1. In the cycle after eoc is seen, adc_oe is 1 for exactly one cycle and adc_data is captured at the end of that cycle. adc_oe is never 1 together with adc_start.
- R4: The first sample captured after reset is only stored. No move is requested for it.
- R5: If new > previous, new ≠ previous, and (new − previous) ≥ min_diff, then mv_req rises two cycles after the adc_oe cycle with mv_dir=1 (forward).
- R6: If previous > new and (previous − new) ≥ min_diff, then mv_req rises at the same point with mv_dir=0 (reverse).
- R7: If the absolute difference is 0 or below min_diff, no move is requested. The new sample still replaces the stored previous value.
- R8: mv_req stays 1 and mv_dir stays stable until mv_done is 1 at a clock edge. mv_req is 0 in the next cycle, and no start strobe occurs while mv_req is 1.
- R9: After the move handshake completes, or after a no-move decision, the next start strobe comes after exactly IDLE_CYCLES cycles of waiting.
- R10: If adc_eoc stays 0 for EOC_TIMEOUT cycles after a start, err_flag is set and the controller returns to the idle wait. In that case adc_oe is never raised and the stored previous value is kept.
- R11: err_flag clears in the cycle in which a later conversion reports end of conversion. It is therefore 0 during that conversion's adc_oe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_diff | input | DATA_W | Smallest code change that causes a move |
| adc_ale | output | 1 | Converter address latch strobe |
| adc_start | output | 1 | Converter start strobe |
| adc_eoc | input | 1 | Converter end of conversion, 1 = result ready |
| adc_oe | output | 1 | Converter output enable, 1 = result on bus |
| adc_data | input | DATA_W | Converter result bus |
| mv_req | output | 1 | Move request (valid) |
| mv_dir | output | 1 | Move direction, 1 = forward, 0 = reverse |
| mv_done | input | 1 | Sequencer completion (ready) |
| err_flag | output | 1 | End-of-conversion timeout seen |

## Verification
Each result has a fixed latency after its stimulus:
- The move request and direction appear two cycles after the output-enable cycle.
- The request drops one cycle after done is accepted.
- The next start strobe follows exactly IDLE_CYCLES cycles after the idle wait is entered.
- The error flag rises EOC_TIMEOUT cycles into an unanswered poll.

The bench samples every output on the falling edge. It counts falling edges from a known anchor, such as the output-enable cycle, the done acceptance or reset release, to the exact cycle in which each value is due. The behavioural converter only puts the table's code on the bus while output enable is high, so a capture at any other cycle reads a wrong value.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_LAUNCH,
    ST_POLL,
    ST_READ,
    ST_DECIDE,
    ST_MOVE
  } lt_state_e;
endpackage

// File: rtl/lt_tick_counter.sv
// Free-running cycle counter with synchronous clear and a terminal-value hit.
module lt_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == last);
endmodule

// File: rtl/lt_delta_judge.sv
// Decides whether a new light code differs enough from the stored one, and which way.
module lt_delta_judge #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] thr,
  input  logic         prev_vld,
  output logic         move,
  output logic         fwd
);
  logic [W-1:0] mag;
  logic         up;

  always_comb begin
    up   = (cur > prev);
    mag  = up ? (cur - prev) : (prev - cur);
    move = prev_vld && (mag != '0) && (mag >= thr);
    fwd  = up;
  end
endmodule

// File: rtl/light_track_ctrl.sv
module light_track_ctrl #(
  parameter int DATA_W      = 8,
  parameter int IDLE_CYCLES = 30000000,
  parameter int EOC_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] min_diff,
  output logic              adc_ale,
  output logic              adc_start,
  input  logic              adc_eoc,
  output logic              adc_oe,
  input  logic [DATA_W-1:0] adc_data,
  output logic              mv_req,
  output logic              mv_dir,
  input  logic              mv_done,
  output logic              err_flag
);
  import lt_pkg::*;

  localparam int LIM_MAX = (IDLE_CYCLES > EOC_TIMEOUT) ? IDLE_CYCLES : EOC_TIMEOUT;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);
  localparam logic [CW-1:0] EOC_LAST  = CW'(EOC_TIMEOUT - 1);

  lt_state_e         state, nxt;
  logic              tick_hit;
  logic [CW-1:0]     tick_last;
  logic [DATA_W-1:0] sample_q, prev_q;
  logic              prev_vld_q;
  logic              dir_q, err_q;
  logic              want_move, want_fwd;

  // One counter serves both the idle interval and the conversion watchdog;
  // it restarts on every state change.
  assign tick_last = (state == ST_POLL) ? EOC_LAST : IDLE_LAST;

  lt_tick_counter #(.W(CW)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (nxt != state),
    .last (tick_last),
    .hit  (tick_hit)
  );

  lt_delta_judge #(.W(DATA_W)) u_judge (
    .cur     (sample_q),
    .prev    (prev_q),
    .thr     (min_diff),
    .prev_vld(prev_vld_q),
    .move    (want_move),
    .fwd     (want_fwd)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WAIT:   if (tick_hit) nxt = ST_LAUNCH;
      ST_LAUNCH: nxt = ST_POLL;
      ST_POLL:   if (adc_eoc) nxt = ST_READ;
                 else if (tick_hit) nxt = ST_WAIT;
      ST_READ:   nxt = ST_DECIDE;
      ST_DECIDE: nxt = want_move ? ST_MOVE : ST_WAIT;
      ST_MOVE:   if (mv_done) nxt = ST_WAIT;
      default:   nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      sample_q   <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      dir_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_READ) sample_q <= adc_data;
      if (state == ST_POLL) begin
        if (adc_eoc)       err_q <= 1'b0;
        else if (tick_hit) err_q <= 1'b1;
      end
      if (state == ST_DECIDE) begin
        dir_q <= want_fwd;
        if (!want_move) begin
          prev_q     <= sample_q;
          prev_vld_q <= 1'b1;
        end
      end
      if (state == ST_MOVE && mv_done) begin
        prev_q     <= sample_q;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assign adc_ale   = (state == ST_LAUNCH);
  assign adc_start = (state == ST_LAUNCH);
  assign adc_oe    = (state == ST_READ);
  assign mv_req    = (state == ST_MOVE);
  assign mv_dir    = dir_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/lt_track_ctrl_chk.sv
module lt_track_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_ale,
  input logic adc_start,
  input logic adc_eoc,
  input logic adc_oe,
  input logic mv_req,
  input logic mv_dir,
  input logic mv_done,
  input logic err_flag
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start && !adc_ale);

  a_r2_ale_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> adc_ale);

  a_r3_oe_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_oe) |-> $past(adc_eoc) && !adc_start);

  a_r3_oe_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |=> !adc_oe);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_done) |=> mv_req && $stable(mv_dir));

  a_r8_req_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && mv_done) |=> !mv_req);

  a_r8_no_start_in_move: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv_req && adc_start));

  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |-> !err_flag);
endmodule

bind light_track_ctrl lt_track_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adc_ale  (adc_ale),
  .adc_start(adc_start),
  .adc_eoc  (adc_eoc),
  .adc_oe   (adc_oe),
  .mv_req   (mv_req),
  .mv_dir   (mv_dir),
  .mv_done  (mv_done),
  .err_flag (err_flag)
);

// File: tb/light_track_ctrl_tb_top.sv
module light_track_ctrl_tb_top;
  localparam int CLK_P    = 10;
  localparam int IDLE_T   = 20;
  localparam int EOC_T    = 16;
  localparam int CONV_LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] min_diff;
  logic       adc_ale, adc_start, adc_oe;
  logic       adc_eoc = 1'b0;
  logic [7:0] adc_data;
  logic       mv_req, mv_dir;
  logic       mv_done;
  logic       err_flag;

  logic [7:0] cur_val;
  logic       eoc_block;
  int         lat = 0;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_P/2) clk = ~clk;

  light_track_ctrl #(
    .DATA_W(8), .IDLE_CYCLES(IDLE_T), .EOC_TIMEOUT(EOC_T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .min_diff(min_diff),
    .adc_ale(adc_ale), .adc_start(adc_start), .adc_eoc(adc_eoc),
    .adc_oe(adc_oe), .adc_data(adc_data),
    .mv_req(mv_req), .mv_dir(mv_dir), .mv_done(mv_done),
    .err_flag(err_flag)
  );

  // Behavioural converter: data only on the bus while output enable is high.
  assign adc_data = adc_oe ? cur_val : 8'h00;

  always @(negedge clk) begin
    if (adc_start) begin
      adc_eoc = 1'b0;
      lat     = CONV_LAT;
    end else if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0 && !eoc_block) adc_eoc = 1'b1;
    end
  end

  // {sample, threshold, expect move, expect forward}
  localparam logic [17:0] VEC [9] = '{
    {8'd100, 8'd5,   1'b0, 1'b0},
    {8'd110, 8'd5,   1'b1, 1'b1},
    {8'd112, 8'd5,   1'b0, 1'b0},
    {8'd107, 8'd5,   1'b1, 1'b0},
    {8'd111, 8'd5,   1'b0, 1'b0},
    {8'd111, 8'd0,   1'b0, 1'b0},
    {8'd255, 8'd100, 1'b1, 1'b1},
    {8'd0,   8'd255, 1'b1, 1'b0},
    {8'd0,   8'd1,   1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the falling edge right after the idle wait was entered.
  task automatic measure_interval(input string tag);
    int found = -1;
    for (int n = 1; n <= IDLE_T + 5; n++) begin
      @(negedge clk);
      if (adc_start) begin found = n; break; end
    end
    check(found == IDLE_T, tag, found, IDLE_T);
    check(adc_ale == 1'b1, "R2 ale with start", int'(adc_ale), 1);
    @(negedge clk);
    check(!adc_start && !adc_ale, "R2 strobes drop", int'(adc_start), 0);
  endtask

  task automatic wait_oe(input string tag);
    bit ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (adc_oe) begin ok = 1; break; end
    end
    check(ok, tag, int'(ok), 1);
    check(!adc_start, "R3 oe apart from start", int'(adc_start), 0);
  endtask

  task automatic handshake(input bit exp_dir);
    repeat (3) @(negedge clk);
    check(mv_req && (mv_dir == exp_dir), "R8 request held", int'(mv_req), 1);
    mv_done = 1'b1;
    @(negedge clk);
    mv_done = 1'b0;
    check(!mv_req, "R8 request released", int'(mv_req), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    mv_done   = 1'b0;
    min_diff  = 8'd0;
    cur_val   = 8'd0;
    eoc_block = 1'b0;
    repeat (3) @(negedge clk);
    check({adc_ale, adc_start, adc_oe, mv_req, err_flag} == 5'b0, "R1 reset outputs",
          int'({adc_ale, adc_start, adc_oe, mv_req, err_flag}), 0);
    rst_n = 1'b1;
    check(!adc_start && !mv_req, "R1 idle after release", int'(adc_start), 0);
    measure_interval("R1 first start");

    for (int i = 0; i < 9; i++) begin
      string tag;
      cur_val  = VEC[i][17:10];
      min_diff = VEC[i][9:2];
      if (i == 0)        tag = "R4 first sample";
      else if (!VEC[i][1]) tag = "R7 no move";
      else if (VEC[i][0])  tag = "R5 forward";
      else                 tag = "R6 reverse";
      wait_oe("R3 oe after eoc");
      repeat (2) @(negedge clk);
      check(mv_req == VEC[i][1], tag, int'(mv_req), int'(VEC[i][1]));
      if (VEC[i][1]) begin
        check(mv_dir == VEC[i][0], tag, int'(mv_dir), int'(VEC[i][0]));
        handshake(VEC[i][0]);
      end
      measure_interval("R9 interval");
    end

    // R10: the converter never answers.
    eoc_block = 1'b1;
    begin
      bit saw_oe = 0;
      bit saw_err = 0;
      for (int i = 0; i < EOC_T + 10; i++) begin
        @(negedge clk);
        if (adc_oe) saw_oe = 1;
        if (err_flag) begin saw_err = 1; break; end
      end
      check(saw_err, "R10 timeout flag", int'(saw_err), 1);
      check(!saw_oe, "R10 no read on timeout", int'(saw_oe), 0);
      check(!mv_req, "R10 no move on timeout", int'(mv_req), 0);
    end
    eoc_block = 1'b0;
    cur_val   = 8'd3;
    min_diff  = 8'd5;
    measure_interval("R10 back to interval");
    wait_oe("R3 oe after recovery");
    check(!err_flag, "R11 flag cleared", int'(err_flag), 0);
    repeat (2) @(negedge clk);
    check(!mv_req, "R10 previous kept", int'(mv_req), 0);
    measure_interval("R9 interval");

    cur_val  = 8'd50;
    min_diff = 8'd10;
    wait_oe("R3 oe");
    repeat (2) @(negedge clk);
    check(mv_req && mv_dir, "R5 forward after recovery", int'(mv_req), 1);
    handshake(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule